// File: doc/BRIEF.md
# Translation Descriptor Output-Address Decoder

This block sits in a page-table walker and turns one 64-bit translation descriptor into two results. The first is the physical address that the descriptor points at: the next-level table base for a table descriptor, or the mapped output address for a block or page descriptor. The second is the shareability attribute for that access. The caller also supplies the walk's controls: the extended-address mode bit, the granule size, the physical-size code and the walk shareability field. For cacheable block/page mappings, it also supplies a flag saying whether the mapping is cacheable.

The extended-address mode changes the meaning of two descriptor bit pairs. With the mode off, descriptor bits 49:48 are ignored, and bits 9:8 carry shareability in block/page entries. With the mode on, bits 49:48 and bits 9:8 become the top four address bits. Shareability for cacheable block/page mappings then comes from the walk shareability field. The physical-size code can still force the top four bits to zero. The result is aligned to the granule. It is held in a single register stage with a valid/ready handshake. A flag marks the reserved shareability code.

Top module: `desc_oa_decoder`

## Requirements
- R1: While reset is asserted and after it is released with no input accepted, `out_valid` is 0 and `in_ready` is 1.
- R2: Output address bits 47 down to the granule boundary equal the same descriptor bits. Bits 11:0 are zero when `gran_16k`=0 (4KB), and bits 13:0 are zero when `gran_16k`=1 (16KB).
- R3: With `lpa_mode`=0, output address bits 51:48 are 0 whatever descriptor bits 49:48 and 9:8 hold.
- R4: With `lpa_mode`=1 and `pa_code`=3'b110, output address bits 49:48 equal descriptor bits 49:48, and output address bits 51:50 equal descriptor bits 9:8. This applies to both descriptor types.
- R5: With `pa_code` other than 3'b110, output address bits 51:48 are 0 for every mode and descriptor type.
- R6: For a table descriptor (`is_table`=1), `out_sh` equals `walk_sh`, and descriptor bits 9:8 have no effect on it.
- R7: For a block/page descriptor with `lpa_mode`=0, `out_sh` equals descriptor bits 9:8.
- R8: For a block/page descriptor with `lpa_mode`=1, `out_sh` equals `walk_sh` when `cacheable`=1, and 2'b10 (outer shareable) when `cacheable`=0.
- R9: The shareability codes are 2'b00 non-shareable, 2'b10 outer and 2'b11 inner. `out_sh_rsvd` is 1 exactly when the registered `out_sh` is the reserved code 2'b01.
- R10: An input accepted on a clock edge (`in_valid` and `in_ready`) appears at the outputs after that edge with `out_valid`=1. While `out_valid`=1 and `out_ready`=0, the outputs hold and `in_ready`=0. `in_ready` = !`out_valid` or `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor and controls are valid |
| in_ready | output | 1 | Stage can accept a descriptor |
| desc | input | 64 | Translation descriptor |
| is_table | input | 1 | 1 = table descriptor, 0 = block/page |
| lpa_mode | input | 1 | Extended (52-bit) address mode |
| gran_16k | input | 1 | 0 = 4KB granule, 1 = 16KB granule |
| pa_code | input | 3 | Physical-size code; 3'b110 selects 52 bits |
| walk_sh | input | 2 | Walk shareability field |
| cacheable | input | 1 | Block/page mapping is cacheable |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 52 | Next-level or output physical address |
| out_sh | output | 2 | Shareability attribute |
| out_sh_rsvd | output | 1 | `out_sh` is the reserved code |

## Verification
Directed descriptors with all bits set are sent in each mode, granule and size code. They show whether the top four bits and the low alignment bits are cleared, or are taken from the two relocated bit pairs. Table and block/page entries with equal bits 9:8 but different walk fields and cacheability tell apart the three shareability sources. Seeded random descriptors mixing all controls are checked against a bench model. A held-back consumer shows whether a waiting result survives a competing input.

// File: rtl/desc_oa_pkg.sv
// Shared widths, codes and result type for the descriptor output-address decoder.
// Assumes a 52-bit physical address space and 64-bit descriptors.
package desc_oa_pkg;
    localparam int DESC_W     = 64;
    localparam int OA_W       = 52;
    localparam int BASE_W     = 48;   // address bits always taken from the descriptor
    localparam int SPLIT_LO   = 8;    // low bit of the relocated pair in extended mode
    localparam int G4K_BITS   = 12;
    localparam int G16K_BITS  = 14;
    localparam logic [2:0] PA_CODE_52 = 3'b110;

    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_RSVD  = 2'b01,
        SH_OUTER = 2'b10,
        SH_INNER = 2'b11
    } share_e;

    typedef struct packed {
        logic [OA_W-1:0] addr;
        share_e          sh;
        logic            sh_rsvd;
    } oa_result_t;
endpackage

// File: rtl/desc_addr_former.sv
// Forms the physical address from a descriptor.
// Assumes granule is 4KB or 16KB; 52-bit reach only when the size code allows it.
module desc_addr_former
    import desc_oa_pkg::*;
#(
    parameter int DW = DESC_W,
    parameter int AW = OA_W,
    parameter int BW = BASE_W,
    parameter int SL = SPLIT_LO,
    parameter int G4 = G4K_BITS,
    parameter int G16 = G16K_BITS
) (
    input  logic [DW-1:0] desc,
    input  logic          lpa_mode,
    input  logic          gran_16k,
    input  logic [2:0]    pa_code,
    output logic [AW-1:0] addr
);
    localparam int EXT_W = AW - BW;   // top bits reached only in extended mode
    localparam int HALF  = EXT_W / 2;

    logic wide_ok;
    assign wide_ok = lpa_mode && (pa_code == PA_CODE_52);

    // Copy base bits, clear the granule offset, then add the extended top bits.
    always_comb begin
        addr = '0;
        addr[BW-1:0] = desc[BW-1:0];
        for (int i = 0; i < G16; i++) begin
            if (i < G4 || gran_16k) addr[i] = 1'b0;
        end
        if (wide_ok) begin
            addr[BW+HALF-1:BW]   = desc[BW+HALF-1:BW];
            addr[AW-1:BW+HALF]   = desc[SL+HALF-1:SL];
        end
    end
endmodule

// File: rtl/desc_share_sel.sv
// Picks the shareability attribute for the access and flags the reserved code.
// Assumes table entries carry no shareability of their own.
module desc_share_sel
    import desc_oa_pkg::*;
(
    input  logic [1:0] desc_sh,
    input  logic       is_table,
    input  logic       lpa_mode,
    input  logic       cacheable,
    input  logic [1:0] walk_sh,
    output share_e     sh,
    output logic       sh_rsvd
);
    // Select the shareability source by descriptor type and address mode.
    always_comb begin
        if (is_table)       sh = share_e'(walk_sh);
        else if (!lpa_mode) sh = share_e'(desc_sh);
        else if (cacheable) sh = share_e'(walk_sh);
        else                sh = SH_OUTER;
    end

    // Mark the reserved shareability encoding.
    assign sh_rsvd = (sh == SH_RSVD);
endmodule

// File: rtl/desc_out_stage.sv
// One-entry registered stage with valid/ready flow control.
// Assumes the consumer may stall indefinitely; data holds while stalled.
module desc_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    // Track whether the stage holds a result.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // Capture data on an accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                    out_data <= '0;
        else if (in_valid && in_ready) out_data <= in_data;
    end
endmodule

// File: rtl/desc_oa_decoder.sv
// Top: descriptor output-address and shareability decoder with one register stage.
// Assumes inputs are held stable while in_valid is high and in_ready is low.
module desc_oa_decoder
    import desc_oa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DESC_W-1:0] desc,
    input  logic              is_table,
    input  logic              lpa_mode,
    input  logic              gran_16k,
    input  logic [2:0]        pa_code,
    input  logic [1:0]        walk_sh,
    input  logic              cacheable,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OA_W-1:0]   out_addr,
    output logic [1:0]        out_sh,
    output logic              out_sh_rsvd
);
    localparam int RW = $bits(oa_result_t);

    oa_result_t res_d, res_q;
    logic [OA_W-1:0] addr_c;
    share_e          sh_c;
    logic            rsvd_c;

    desc_addr_former u_addr (
        .desc     (desc),
        .lpa_mode (lpa_mode),
        .gran_16k (gran_16k),
        .pa_code  (pa_code),
        .addr     (addr_c)
    );

    desc_share_sel u_share (
        .desc_sh   (desc[SPLIT_LO+1:SPLIT_LO]),
        .is_table  (is_table),
        .lpa_mode  (lpa_mode),
        .cacheable (cacheable),
        .walk_sh   (walk_sh),
        .sh        (sh_c),
        .sh_rsvd   (rsvd_c)
    );

    // Pack the combinational result for the register stage.
    always_comb begin
        res_d.addr    = addr_c;
        res_d.sh      = sh_c;
        res_d.sh_rsvd = rsvd_c;
    end

    desc_out_stage #(.W(RW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (res_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (res_q)
    );

    assign out_addr    = res_q.addr;
    assign out_sh      = res_q.sh;
    assign out_sh_rsvd = res_q.sh_rsvd;
endmodule

// File: rtl/desc_oa_decoder_chk.sv
// Assertion checker for desc_oa_decoder, bound to every instance.
module desc_oa_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [63:0] desc,
    input logic        is_table,
    input logic        lpa_mode,
    input logic        gran_16k,
    input logic [2:0]  pa_code,
    input logic [1:0]  walk_sh,
    input logic        cacheable,
    input logic        out_valid,
    input logic        out_ready,
    input logic [51:0] out_addr,
    input logic [1:0]  out_sh,
    input logic        out_sh_rsvd
);
    logic fire;
    assign fire = in_valid && in_ready;

    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid); // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_sh))); // R10
    AST_GRAN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && gran_16k) |=> (out_addr[13:0] == 14'd0)); // R2
    AST_DS0_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !lpa_mode) |=> (out_addr[51:48] == 4'd0)); // R3
    AST_LPA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && lpa_mode && pa_code == 3'b110) |=>
        (out_addr[51:48] == {$past(desc[9:8]), $past(desc[49:48])})); // R4
    AST_PA_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pa_code != 3'b110) |=> (out_addr[51:48] == 4'd0)); // R5
    AST_TABLE_SH: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_table) |=> (out_sh == $past(walk_sh))); // R6
    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sh_rsvd == (out_sh == 2'b01))); // R9
endmodule

bind desc_oa_decoder desc_oa_decoder_chk chk_i (.*);

// File: tb/desc_oa_decoder_test.sv
module desc_oa_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] desc = '0;
    logic        is_table = 1'b0;
    logic        lpa_mode = 1'b0;
    logic        gran_16k = 1'b0;
    logic [2:0]  pa_code = 3'd0;
    logic [1:0]  walk_sh = 2'd0;
    logic        cacheable = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [51:0] out_addr;
    logic [1:0]  out_sh;
    logic        out_sh_rsvd;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    desc_oa_decoder uut (.*);

    function automatic logic [51:0] exp_addr(logic [63:0] d, logic ds, logic g16, logic [2:0] pa);
        logic [51:0] a;
        a = {4'b0, d[47:0]};
        if (g16) a[13:0] = '0; else a[11:0] = '0;
        if (ds && pa == 3'b110) a[51:48] = {d[9:8], d[49:48]};
        return a;
    endfunction

    function automatic logic [1:0] exp_sh(logic [63:0] d, logic t, logic ds, logic c, logic [1:0] w);
        if (t) return w;
        if (!ds) return d[9:8];
        if (c) return w;
        return 2'b10;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one descriptor, let it be taken, and stop at the next falling edge.
    task automatic apply(input logic [63:0] d, input logic t, input logic ds, input logic g,
                         input logic [2:0] pa, input logic [1:0] w, input logic c);
        @(negedge clk);
        desc = d; is_table = t; lpa_mode = ds; gran_16k = g;
        pa_code = pa; walk_sh = w; cacheable = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic t, ds, g, c;
        logic [2:0] pa;
        logic [1:0] w;
        void'($urandom(32'h5eed_0042));

        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        chk("R1 ready in reset", {63'd0, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {63'd0, out_valid}, 64'd0);

        // R2 / R3: all-ones descriptor, normal mode, both granules
        apply('1, 1'b0, 1'b0, 1'b0, 3'b110, 2'b00, 1'b0);
        chk("R3 4KB addr", {12'd0, out_addr}, 64'h0000_FFFF_FFFF_F000);
        chk("R10 valid after accept", {63'd0, out_valid}, 64'd1);
        apply('1, 1'b0, 1'b0, 1'b1, 3'b110, 2'b00, 1'b0);
        chk("R2 16KB addr", {12'd0, out_addr}, 64'h0000_FFFF_FFFF_C000);

        // R4 / R5: relocated bit pairs
        d = 64'h0000_8000_0000_0000;
        d[49:48] = 2'b10; d[9:8] = 2'b01;
        apply(d, 1'b1, 1'b1, 1'b0, 3'b110, 2'b11, 1'b0);
        chk("R4 table wide addr", {12'd0, out_addr}, 64'h0006_8000_0000_0000);
        apply(d, 1'b0, 1'b1, 1'b0, 3'b110, 2'b11, 1'b1);
        chk("R4 block wide addr", {12'd0, out_addr}, 64'h0006_8000_0000_0000);
        apply(d, 1'b1, 1'b1, 1'b0, 3'b101, 2'b11, 1'b0);
        chk("R5 clamp addr", {12'd0, out_addr}, 64'h0000_8000_0000_0000);

        // R6 .. R9: shareability sources
        d = '0; d[9:8] = 2'b11;
        apply(d, 1'b1, 1'b0, 1'b0, 3'b000, 2'b00, 1'b1);
        chk("R6 table ignores bits 9:8", {62'd0, out_sh}, 64'd0);
        apply(d, 1'b0, 1'b0, 1'b0, 3'b000, 2'b00, 1'b0);
        chk("R7 block sh from desc", {62'd0, out_sh}, 64'd3);
        d[9:8] = 2'b01;
        apply(d, 1'b0, 1'b0, 1'b0, 3'b000, 2'b10, 1'b0);
        chk("R9 rsvd flag set", {63'd0, out_sh_rsvd}, 64'd1);
        apply(d, 1'b0, 1'b1, 1'b0, 3'b000, 2'b11, 1'b1);
        chk("R8 cacheable uses walk_sh", {62'd0, out_sh}, 64'd3);
        chk("R9 rsvd flag clear", {63'd0, out_sh_rsvd}, 64'd0);
        apply(d, 1'b0, 1'b1, 1'b0, 3'b000, 2'b11, 1'b0);
        chk("R8 noncacheable outer", {62'd0, out_sh}, 64'd2);

        // R10: back-pressure holds the waiting result
        @(negedge clk);
        out_ready = 1'b0;
        apply(64'h0000_1234_5678_9000, 1'b0, 1'b0, 1'b0, 3'b000, 2'b00, 1'b0);
        chk("R10 ready low when stalled", {63'd0, in_ready}, 64'd0);
        desc = 64'h0000_0000_0000_A000; in_valid = 1'b1;
        @(negedge clk);
        chk("R10 held addr", {12'd0, out_addr}, 64'h0000_1234_5678_9000);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 next taken", {12'd0, out_addr}, 64'h0000_0000_0000_A000);
        @(negedge clk);
        chk("R10 drained", {63'd0, out_valid}, 64'd0);

        // Seeded random mix checked against the bench model
        for (int i = 0; i < 400; i++) begin
            d  = {$urandom, $urandom};
            t  = $urandom_range(0, 1);
            ds = $urandom_range(0, 1);
            g  = $urandom_range(0, 1);
            pa = ($urandom_range(0, 1) == 1) ? 3'b110 : 3'($urandom_range(0, 7));
            w  = 2'($urandom_range(0, 3));
            c  = $urandom_range(0, 1);
            apply(d, t, ds, g, pa, w, c);
            chk(!ds ? "R3 rand addr" : (pa != 3'b110 ? "R5 rand addr" : "R4 rand addr"),
                {12'd0, out_addr}, {12'd0, exp_addr(d, ds, g, pa)});
            chk(t ? "R6 rand sh" : (ds ? "R8 rand sh" : "R7 rand sh"),
                {62'd0, out_sh}, {62'd0, exp_sh(d, t, ds, c, w)});
            chk("R9 rand rsvd", {63'd0, out_sh_rsvd},
                {63'd0, exp_sh(d, t, ds, c, w) == 2'b01});
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule